// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block evaluates a set of Boolean functions in sum-of-products form. Both planes are held in configuration registers. One row of this personality belongs to each product term. A row holds a 2-bit literal code for every input, which selects the true literal, the complemented literal or no connection. It also holds one connection bit per output. Each output is the OR of the product terms connected to it. One term may drive several outputs, so terms that functions have in common are stored only once. The path from `in_vec` to `out_vec` has no registers.

A synchronous write port loads one whole row per clock edge. Software-free configuration logic, such as a boot sequencer, sets the functions by writing one row for each term it needs. When `pal_mode` is high, the OR plane becomes fixed. Output j may then use only its own contiguous group of P/M terms, and connection bits outside that group have no effect. A write whose row index lies outside the array changes nothing and sets a sticky error flag.

Top module: `pla_engine`

## Requirements
- R1: The literal code of input i sits at bits [2i+1:2i] of a row's code. Code 2'b10 requires the input to be 1, code 2'b01 requires it to be 0, and code 2'b00 leaves the input out of the term.
- R2: Code 2'b11 on any input forces its term to 0. A term whose codes are all 2'b00 is 1 for every input value.
- R3: Output bit j is the OR of every term whose mask bit j is 1. A term may be connected to several outputs at once. A term with an all-zero mask has no effect.
- R4: When `pal_mode` is 1, output j uses only terms j*G to j*G+G-1, where G = P/M. Mask bits that connect a term outside that group are ignored. When `pal_mode` is 0, every term is available to every output.
- R5: When `wr_en` is 1 at a rising clock edge and `wr_term` < P, that row's code and mask are replaced. `out_vec` shows the new row from that edge onward and never before it. `out_vec` follows `in_vec` and `pal_mode` with no clock delay.
- R6: A write with `wr_term` >= P changes no row and sets `wr_err`. `wr_err` stays 1 until reset.
- R7: A synchronous active-high reset clears every row code and mask and clears `wr_err`. After reset, `out_vec` is all zeros for every input.
- R8: At a clock edge where `wr_en` is 0, no row changes, whatever values the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rows and error flag update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pal_mode | input | 1 | 1 restricts each output to its own term group |
| wr_en | input | 1 | Row write request |
| wr_term | input | $clog2(P)+1 | Row index of the write |
| wr_code | input | 2N | Literal codes of the row, 2 bits per input |
| wr_mask | input | M | Output connections of the row |
| in_vec | input | N | Function inputs |
| out_vec | output | M | Function outputs |
| wr_err | output | 1 | Sticky out-of-range write flag |

## Verification
The bench builds the block with N=4, P=16 and M=4. This gives 4-term groups in the restricted mode and a 5-bit row index, so indices 16 to 31 are out of range. With these values a four-input code converter fits in both modes, including an output that needs four terms. The 5-bit index also lets the bench write to index 16, which a design that dropped the top index bit would alias onto row 0. A three-input personality with shared terms is run over all input values, with the fourth input left out of every term.

// File: rtl/pla_cfg_pkg.sv
package pla_cfg_pkg;

    // Two-bit literal code per input inside a product-term row.
    typedef enum logic [1:0] {
        LIT_NONE = 2'b00,   // input absent from the term
        LIT_COMP = 2'b01,   // input must be 0
        LIT_TRUE = 2'b10,   // input must be 1
        LIT_BOTH = 2'b11    // both polarities: term can never be true
    } lit_code_e;

    // Width of the row index: one spare bit so out-of-range indices exist.
    function automatic int row_index_width(input int rows);
        return $clog2(rows) + 1;
    endfunction

    // Does one input value satisfy one literal code?
    function automatic logic lit_pass(input lit_code_e code, input logic x);
        logic need_one;
        logic need_zero;
        need_one  = code[1];
        need_zero = code[0];
        return (!need_one || x) && (!need_zero || !x);
    endfunction

    // Is term t inside the fixed group of output j?
    function automatic logic in_term_group(input int t, input int j, input int group);
        return (t >= j * group) && (t < (j + 1) * group);
    endfunction

endpackage

// File: rtl/pla_row_store.sv
module pla_row_store #(
    parameter int N     = 4,
    parameter int P     = 8,
    parameter int M     = 4,
    parameter int IDX_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_term,
    input  logic [2*N-1:0]            wr_code,
    input  logic [M-1:0]              wr_mask,
    output logic [P-1:0][2*N-1:0]     row_code,
    output logic [P-1:0][M-1:0]       row_mask,
    output logic                      wr_err
);
    localparam logic [IDX_W-1:0] ROW_LIMIT = IDX_W'(P);

    logic index_ok;
    logic err_q;

    assign index_ok = (wr_term < ROW_LIMIT);

    generate
        for (genvar t = 0; t < P; t++) begin : g_row
            localparam logic [IDX_W-1:0] ROW_ID = IDX_W'(t);
            logic              row_sel;
            logic [2*N-1:0]    code_q;
            logic [M-1:0]      mask_q;

            assign row_sel = wr_en && index_ok && (wr_term == ROW_ID);

            always_ff @(posedge clk) begin
                if (rst) begin
                    code_q <= '0;
                    mask_q <= '0;
                end else if (row_sel) begin
                    code_q <= wr_code;
                    mask_q <= wr_mask;
                end
            end

            assign row_code[t] = code_q;
            assign row_mask[t] = mask_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (wr_en && !index_ok) begin
            err_q <= 1'b1;
        end
    end

    assign wr_err = err_q;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_cfg_pkg::*;
#(
    parameter int N = 4,
    parameter int P = 8
) (
    input  logic [P-1:0][2*N-1:0] row_code,
    input  logic [N-1:0]          in_vec,
    output logic [P-1:0]          term_hit
);
    generate
        for (genvar t = 0; t < P; t++) begin : g_term
            logic hit;

            always_comb begin
                hit = 1'b1;
                for (int i = 0; i < N; i++) begin
                    hit = hit & lit_pass(lit_code_e'(row_code[t][2*i +: 2]), in_vec[i]);
                end
            end

            assign term_hit[t] = hit;
        end
    endgenerate

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_cfg_pkg::*;
#(
    parameter int P = 8,
    parameter int M = 4
) (
    input  logic [P-1:0]          term_hit,
    input  logic [P-1:0][M-1:0]   row_mask,
    input  logic                  pal_mode,
    output logic [M-1:0]          out_vec
);
    localparam int GROUP = P / M;

    generate
        for (genvar j = 0; j < M; j++) begin : g_out
            logic [P-1:0] feeds;

            always_comb begin
                for (int t = 0; t < P; t++) begin
                    feeds[t] = term_hit[t] && row_mask[t][j]
                               && (!pal_mode || in_term_group(t, j, GROUP));
                end
            end

            assign out_vec[j] = |feeds;
        end
    endgenerate

endmodule

// File: rtl/pla_engine.sv
module pla_engine
    import pla_cfg_pkg::*;
#(
    parameter int  N     = 4,
    parameter int  P     = 8,
    parameter int  M     = 4,
    localparam int IDX_W = row_index_width(P)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pal_mode,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_term,
    input  logic [2*N-1:0]   wr_code,
    input  logic [M-1:0]     wr_mask,
    input  logic [N-1:0]     in_vec,
    output logic [M-1:0]     out_vec,
    output logic             wr_err
);
    logic [P-1:0][2*N-1:0] row_code;
    logic [P-1:0][M-1:0]   row_mask;
    logic [P-1:0]          term_hit;

    pla_row_store #(.N(N), .P(P), .M(M), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_term  (wr_term),
        .wr_code  (wr_code),
        .wr_mask  (wr_mask),
        .row_code (row_code),
        .row_mask (row_mask),
        .wr_err   (wr_err)
    );

    pla_and_plane #(.N(N), .P(P)) u_and (
        .row_code (row_code),
        .in_vec   (in_vec),
        .term_hit (term_hit)
    );

    pla_or_plane #(.P(P), .M(M)) u_or (
        .term_hit (term_hit),
        .row_mask (row_mask),
        .pal_mode (pal_mode),
        .out_vec  (out_vec)
    );

endmodule

// File: rtl/pla_engine_chk.sv
module pla_engine_chk
    import pla_cfg_pkg::*;
#(
    parameter int  N     = 4,
    parameter int  P     = 8,
    parameter int  M     = 4,
    localparam int IDX_W = row_index_width(P)
) (
    input logic             clk,
    input logic             rst,
    input logic             pal_mode,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_term,
    input logic [N-1:0]     in_vec,
    input logic [M-1:0]     out_vec,
    input logic             wr_err
);
    localparam logic [IDX_W-1:0] ROW_LIMIT = IDX_W'(P);

    logic bad_write;
    assign bad_write = wr_en && (wr_term >= ROW_LIMIT);

    // R7: the first edge after reset sees a cleared array and flag
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_vec == '0) && !wr_err);

    // R6: an out-of-range write raises the flag
    p_bad_index_r6: assert property (@(posedge clk) disable iff (rst)
        bad_write |=> wr_err);

    // R6: the flag is sticky until reset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err);

    // R6: the flag rises only after an out-of-range write
    p_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_err) |-> $past(bad_write));

    // R8 and R6: with no accepted write and steady inputs, outputs hold
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!wr_en || (wr_term >= ROW_LIMIT))
         && $stable(in_vec) && $stable(pal_mode)) |-> $stable(out_vec));

endmodule

bind pla_engine pla_engine_chk #(.N(N), .P(P), .M(M)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pal_mode (pal_mode),
    .wr_en    (wr_en),
    .wr_term  (wr_term),
    .in_vec   (in_vec),
    .out_vec  (out_vec),
    .wr_err   (wr_err)
);

// File: tb/pla_engine_tb_top.sv
`timescale 1ns/1ps
module pla_engine_tb_top;
    localparam int N     = 4;
    localparam int P     = 16;
    localparam int M     = 4;
    localparam int IDX_W = 5;

    // Gray converter table: upper nibble input (A=bit3..D=bit0), lower nibble {W,X,Y,Z}
    localparam logic [7:0] GRAY_TAB [10] = '{8'h00, 8'h11, 8'h23, 8'h32, 8'h46,
                                             8'h5E, 8'h6A, 8'h7B, 8'h89, 8'h98};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pal_mode = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_term = '0;
    logic [2*N-1:0]   wr_code = '0;
    logic [M-1:0]     wr_mask = '0;
    logic [N-1:0]     in_vec = '0;
    logic [M-1:0]     out_vec;
    logic             wr_err;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pla_engine #(.N(N), .P(P), .M(M)) dut_i (
        .clk(clk), .rst(rst), .pal_mode(pal_mode), .wr_en(wr_en),
        .wr_term(wr_term), .wr_code(wr_code), .wr_mask(wr_mask),
        .in_vec(in_vec), .out_vec(out_vec), .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_row(input int idx, input logic [7:0] code, input logic [3:0] mask);
        @(negedge clk);
        wr_en = 1'b1; wr_term = IDX_W'(idx); wr_code = code; wr_mask = mask;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_rows();
        for (int t = 0; t < P; t++) write_row(t, 8'h00, 4'h0);
    endtask

    task automatic apply(input logic [3:0] v);
        @(negedge clk);
        in_vec = v;
        #2;
    endtask

    function automatic logic [3:0] ex1_expect(input logic [3:0] v);
        logic a, b, c;
        a = v[3]; b = v[2]; c = v[1];
        return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
    endfunction

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++; n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        apply(4'hF); check("R7 reset out", out_vec, 4'h0);
        check("R7 reset err", {3'b0, wr_err}, 4'h0);
        apply(4'h0); check("R7 reset out zero input", out_vec, 4'h0);

        // R1 R3: three-input personality with shared terms, D in no term
        write_row(0, 8'b10_10_00_00, 4'b0110);
        write_row(1, 8'b00_01_10_00, 4'b1000);
        write_row(2, 8'b10_00_01_00, 4'b0010);
        write_row(3, 8'b00_01_01_00, 4'b0101);
        write_row(4, 8'b10_00_00_00, 4'b1001);
        for (int v = 0; v < 16; v++) begin
            apply(4'(v));
            check("R1 R3 shared terms", out_vec, ex1_expect(4'(v)));
        end

        // R3: PLA-mode code converter, walked through the table
        clear_rows();
        write_row(0, 8'b10_00_00_00, 4'b1000);
        write_row(1, 8'b00_10_00_10, 4'b1000);
        write_row(2, 8'b00_10_10_00, 4'b1000);
        write_row(3, 8'b00_10_01_00, 4'b0100);
        write_row(4, 8'b00_10_00_00, 4'b0010);
        write_row(5, 8'b00_00_10_00, 4'b0010);
        write_row(6, 8'b01_01_01_10, 4'b0001);
        write_row(7, 8'b00_10_10_10, 4'b0001);
        write_row(8, 8'b10_00_00_01, 4'b0001);
        write_row(9, 8'b00_01_10_01, 4'b0001);
        for (int k = 0; k < 10; k++) begin
            apply(GRAY_TAB[k][7:4]);
            check("R3 converter PLA", out_vec, GRAY_TAB[k][3:0]);
        end

        // R4: PAL mode, every mask all ones; groups decide
        clear_rows();
        write_row(0,  8'b01_01_01_10, 4'hF);
        write_row(1,  8'b00_10_10_10, 4'hF);
        write_row(2,  8'b10_00_00_01, 4'hF);
        write_row(3,  8'b00_01_10_01, 4'hF);
        write_row(4,  8'b00_10_00_00, 4'hF);
        write_row(5,  8'b00_00_10_00, 4'hF);
        write_row(6,  8'b11_00_00_00, 4'hF);
        write_row(7,  8'b11_00_00_00, 4'hF);
        write_row(8,  8'b00_10_01_00, 4'hF);
        write_row(9,  8'b11_00_00_00, 4'hF);
        write_row(10, 8'b11_00_00_00, 4'hF);
        write_row(11, 8'b11_00_00_00, 4'hF);
        write_row(12, 8'b10_00_00_00, 4'hF);
        write_row(13, 8'b00_10_00_10, 4'hF);
        write_row(14, 8'b00_10_10_00, 4'hF);
        write_row(15, 8'b11_00_00_00, 4'hF);
        pal_mode = 1'b1;
        for (int k = 0; k < 10; k++) begin
            apply(GRAY_TAB[k][7:4]);
            check("R4 converter PAL groups", out_vec, GRAY_TAB[k][3:0]);
        end
        // R4: same rows without the restriction, all terms reach all outputs
        pal_mode = 1'b0;
        apply(4'h1); check("R4 PLA mode ignores groups", out_vec, 4'hF);
        apply(4'h0); check("R4 PLA mode zero input", out_vec, 4'h0);
        // R5: mode change seen without a clock edge
        @(negedge clk); in_vec = 4'h3; pal_mode = 1'b1; #1;
        check("R5 combinational mode path", out_vec, 4'h2);
        pal_mode = 1'b0;

        // R2: code 11 forces zero, all-absent term is one
        clear_rows();
        write_row(2, 8'b00_00_00_00, 4'b0001);
        write_row(3, 8'b11_00_00_00, 4'b0010);
        write_row(4, 8'b00_00_11_00, 4'b0100);
        write_row(5, 8'b00_10_00_00, 4'b0000);
        apply(4'h0); check("R2 empty term true", out_vec, 4'b0001);
        apply(4'hF); check("R2 both-polarity term false", out_vec, 4'b0001);
        apply(4'h4); check("R3 unconnected term no effect", out_vec, 4'b0001);

        // R8: write fields toggle with wr_en low
        @(negedge clk);
        wr_en = 1'b0; wr_term = 5'd6; wr_code = 8'h00; wr_mask = 4'hF;
        @(negedge clk); #2;
        check("R8 no write when disabled", out_vec, 4'b0001);

        // R5: write latency, sampled before and after the accepting edge
        @(negedge clk);
        wr_en = 1'b1; wr_term = 5'd7; wr_code = 8'h00; wr_mask = 4'b1000;
        #5; check("R5 before edge", out_vec, 4'b0001);
        @(posedge clk); #1;
        check("R5 after edge", out_vec, 4'b1001);
        @(negedge clk); wr_en = 1'b0;

        // R6: out-of-range writes ignored, flag sticky
        write_row(16, 8'h00, 4'hF);
        apply(4'hF); check("R6 index 16 ignored", out_vec, 4'b1001);
        check("R6 flag set", {3'b0, wr_err}, 4'h1);
        write_row(31, 8'h00, 4'b0110);
        apply(4'h0); check("R6 index 31 ignored", out_vec, 4'b1001);
        write_row(6, 8'h00, 4'b0100);
        apply(4'h0); check("R6 later good write lands", out_vec, 4'b1101);
        check("R6 flag sticky", {3'b0, wr_err}, 4'h1);

        // R7: reset clears rows and flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #2;
        check("R7 reset clears rows", out_vec, 4'h0);
        check("R7 reset clears flag", {3'b0, wr_err}, 4'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule